// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This block holds the per-bank row state that an SDRAM controller's scheduler consults before it issues a command. It notes which banks currently have a row open and which row that is. It watches the commands the controller issues: activate, precharge of one bank, precharge of every bank, read and write. It turns any command that breaks the bank rules into a one-cycle error pulse, and it leaves the stored state untouched when that happens.

A separate query port takes a bank and a row. It answers combinationally from the stored state with one of three results: hit (the bank is open on that row), miss (the bank is open on another row) or idle (the bank has no open row). The scheduler uses that answer to pick between a direct column access, a precharge followed by an activate, or a plain activate.

The `NUM_BANKS` parameter picks the device organisation. Use 4 for devices of up to 512 Mb and 8 for devices from 1 Gb to 4 Gb. With eight banks, no more than four banks may be open at once.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset every bank is idle, so a query of any bank returns idle, and `err` is low.
- R2: An activate (`cmd_op` = 2'b00) to an idle bank, while the open-bank limit is not reached, opens that bank on `cmd_row`. From the next cycle, a query of that bank and row returns hit, and a query of that bank with another row returns miss.
- R3: A precharge (`cmd_op` = 2'b01) with `cmd_all` = 0 closes the addressed bank from the next cycle on. A precharge to a bank that is already idle is legal and changes nothing.
- R4: A precharge with `cmd_all` = 1 closes every bank in one cycle, whatever `cmd_bank` holds. It also resets the open-bank count, so the full limit of banks can be opened again afterwards.
- R5: The query outputs depend only on the stored state and on `q_bank`/`q_row`, with no register in between. Exactly one of `q_hit`, `q_miss` and `q_idle` is high at any time.
- R6: An activate to a bank that already has an open row is illegal. It raises `err` and leaves every bank's state unchanged.
- R7: A read (`cmd_op` = 2'b10) or write (`cmd_op` = 2'b11) to an idle bank, or to a row other than the open one, is illegal. It raises `err` and changes no state. A read or write to the open row is legal and changes no state.
- R8: With `NUM_BANKS` = 8, an activate that would open a fifth bank is refused. It raises `err` and the bank stays idle.
- R9: With `NUM_BANKS` = 4, all four banks may be open at the same time without error.
- R10: `err` is registered. It is high for exactly the one cycle after an illegal command and low after any cycle with `cmd_valid` low or with a legal command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | 00 activate, 01 precharge, 10 read, 11 write |
| cmd_all | input | 1 | With precharge: close every bank |
| cmd_bank | input | $clog2(NUM_BANKS) | Bank addressed by the command |
| cmd_row | input | ROW_W | Row addressed by activate, read or write |
| q_bank | input | $clog2(NUM_BANKS) | Bank to query |
| q_row | input | ROW_W | Row to query |
| q_hit | output | 1 | Queried bank is open on the queried row |
| q_miss | output | 1 | Queried bank is open on a different row |
| q_idle | output | 1 | Queried bank has no open row |
| err | output | 1 | Previous cycle's command was illegal |

## Verification
The bench builds two copies side by side from the same command stream. One copy has `NUM_BANKS` = 8, which makes the four-open-bank refusal reachable. The other has `NUM_BANKS` = 4 and sees only the low two bank bits, which shows that all four banks can be open together with no limit firing. Both copies use an 8-bit row, and rows are drawn from a small set, so hits, misses and wrong-row reads and writes happen often. Because the two copies receive the same commands but see different bank sets, the same command can be legal in one and illegal in the other.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_PRE = 2'b01,
        OP_RD  = 2'b10,
        OP_WR  = 2'b11
    } brt_op_e;

    // Limit on simultaneously open banks for the eight-bank organisation
    localparam int BRT_WIDE_CAP = 4;

endpackage

// File: rtl/brt_query.sv
// Combinational row-hit / row-miss / idle lookup on the stored bank state
module brt_query #(
    parameter int NB    = 8,
    parameter int ROW_W = 14,
    localparam int BW   = $clog2(NB)
) (
    input  logic [NB-1:0]            open_vec,
    input  logic [NB-1:0][ROW_W-1:0] rows,
    input  logic [BW-1:0]            q_bank,
    input  logic [ROW_W-1:0]         q_row,
    output logic                     q_hit,
    output logic                     q_miss,
    output logic                     q_idle
);

    logic row_eq;

    always_comb begin
        row_eq = (rows[q_bank] == q_row);
        q_hit  = open_vec[q_bank] &&  row_eq;
        q_miss = open_vec[q_bank] && !row_eq;
        q_idle = !open_vec[q_bank];
    end

endmodule

// File: rtl/brt_legal.sv
// Decodes one command against the stored state into an update request or an error
module brt_legal
    import brt_pkg::*;
#(
    parameter int NB    = 8,
    parameter int ROW_W = 14,
    parameter int CAP   = 4,
    localparam int BW   = $clog2(NB),
    localparam int CW   = $clog2(NB + 1)
) (
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic                     cmd_all,
    input  logic [BW-1:0]            cmd_bank,
    input  logic [ROW_W-1:0]         cmd_row,
    input  logic [NB-1:0]            open_vec,
    input  logic [NB-1:0][ROW_W-1:0] rows,
    input  logic [CW-1:0]            open_cnt,
    output logic                     illegal,
    output logic                     open_en,
    output logic                     close_en,
    output logic                     close_all
);

    localparam logic [CW-1:0] CAP_V = CW'(CAP);

    logic bank_open;
    logic limit_hit;

    always_comb begin
        bank_open = open_vec[cmd_bank];
        limit_hit = (open_cnt >= CAP_V);
        illegal   = 1'b0;
        open_en   = 1'b0;
        close_en  = 1'b0;
        close_all = 1'b0;
        if (cmd_valid) begin
            unique case (brt_op_e'(cmd_op))
                OP_ACT: begin
                    if (bank_open || limit_hit) illegal = 1'b1;
                    else                        open_en = 1'b1;
                end
                OP_PRE: begin
                    if (cmd_all)        close_all = 1'b1;
                    else if (bank_open) close_en  = 1'b1;
                end
                OP_RD, OP_WR: begin
                    illegal = !bank_open || (rows[cmd_bank] != cmd_row);
                end
                default: illegal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/bank_row_tracker.sv
// Per-bank open-row tracker: state registers, update logic and query port
module bank_row_tracker
    import brt_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(NUM_BANKS + 1),
    localparam int OPEN_CAP = (NUM_BANKS > 4) ? BRT_WIDE_CAP : NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_all,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic              q_hit,
    output logic              q_miss,
    output logic              q_idle,
    output logic              err
);

    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][ROW_W-1:0] rows;
        logic [CNT_W-1:0]                cnt;
        logic                            err;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [NUM_BANKS-1:0]            open_q;
    logic [NUM_BANKS-1:0][ROW_W-1:0] rows_q;
    logic [CNT_W-1:0]                cnt_q;

    logic illegal, open_en, close_en, close_all;

    assign open_q = st_q.open;
    assign rows_q = st_q.rows;
    assign cnt_q  = st_q.cnt;
    assign err    = st_q.err;

    brt_legal #(
        .NB    (NUM_BANKS),
        .ROW_W (ROW_W),
        .CAP   (OPEN_CAP)
    ) u_legal (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_all   (cmd_all),
        .cmd_bank  (cmd_bank),
        .cmd_row   (cmd_row),
        .open_vec  (open_q),
        .rows      (rows_q),
        .open_cnt  (cnt_q),
        .illegal   (illegal),
        .open_en   (open_en),
        .close_en  (close_en),
        .close_all (close_all)
    );

    brt_query #(
        .NB    (NUM_BANKS),
        .ROW_W (ROW_W)
    ) u_query (
        .open_vec (open_q),
        .rows     (rows_q),
        .q_bank   (q_bank),
        .q_row    (q_row),
        .q_hit    (q_hit),
        .q_miss   (q_miss),
        .q_idle   (q_idle)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = illegal;
        if (close_all) begin
            st_d.open = '0;
            st_d.cnt  = '0;
        end else if (close_en) begin
            st_d.open[cmd_bank] = 1'b0;
            st_d.cnt            = st_q.cnt - 1'b1;
        end else if (open_en) begin
            st_d.open[cmd_bank] = 1'b1;
            st_d.rows[cmd_bank] = cmd_row;
            st_d.cnt            = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/brt_checker.sv
// Property checker bound to the tracker
module brt_checker
    import brt_pkg::*;
#(
    parameter int NB    = 8,
    parameter int ROW_W = 14,
    parameter int CAP   = 4,
    localparam int BW   = $clog2(NB),
    localparam int CW   = $clog2(NB + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [1:0]               cmd_op,
    input logic                     cmd_all,
    input logic [BW-1:0]            cmd_bank,
    input logic [ROW_W-1:0]         cmd_row,
    input logic [NB-1:0]            open_vec,
    input logic [NB-1:0][ROW_W-1:0] rows,
    input logic [CW-1:0]            open_cnt,
    input logic                     q_hit,
    input logic                     q_miss,
    input logic                     q_idle,
    input logic                     err
);

    localparam logic [CW-1:0] CAP_V = CW'(CAP);

    // R2: legal activate opens the bank on the requested row
    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && !open_vec[cmd_bank] && open_cnt < CAP_V)
        |=> (open_vec[$past(cmd_bank)] && rows[$past(cmd_bank)] == $past(cmd_row)));

    // R4: precharge of all banks empties the table
    p_pall_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PRE && cmd_all) |=> (open_vec == '0 && open_cnt == '0));

    // R5: query result is one-hot
    p_query_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({q_hit, q_miss, q_idle}) == 1);

    // R6, R7: an error leaves the state untouched
    p_err_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (open_vec == $past(open_vec) && rows == $past(rows)));

    // R7: column access to an idle bank is flagged
    p_rdwr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && !open_vec[cmd_bank]) |=> err);

    // R8: open-bank count never passes the limit and tracks the bank vector
    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(open_vec) <= CAP) && ($countones(open_vec) == int'(open_cnt)));

    // R10: no command, no error
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !err);

endmodule

bind bank_row_tracker brt_checker #(
    .NB    (NUM_BANKS),
    .ROW_W (ROW_W),
    .CAP   (OPEN_CAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_all   (cmd_all),
    .cmd_bank  (cmd_bank),
    .cmd_row   (cmd_row),
    .open_vec  (open_q),
    .rows      (rows_q),
    .open_cnt  (cnt_q),
    .q_hit     (q_hit),
    .q_miss    (q_miss),
    .q_idle    (q_idle),
    .err       (err)
);

// File: tb/tb_bank_row_tracker.sv
module tb_bank_row_tracker;

    localparam int RW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          v;
    logic [1:0]    op;
    logic          all;
    logic [2:0]    b;
    logic [RW-1:0] r;
    logic [2:0]    qb;
    logic [RW-1:0] qr;
    logic h8, m8, i8, e8, h4, m4, i4, e4;

    bank_row_tracker #(.NUM_BANKS(8), .ROW_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(v), .cmd_op(op), .cmd_all(all),
        .cmd_bank(b), .cmd_row(r), .q_bank(qb), .q_row(qr),
        .q_hit(h8), .q_miss(m8), .q_idle(i8), .err(e8));

    bank_row_tracker #(.NUM_BANKS(4), .ROW_W(RW)) dut4 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(v), .cmd_op(op), .cmd_all(all),
        .cmd_bank(b[1:0]), .cmd_row(r), .q_bank(qb[1:0]), .q_row(qr),
        .q_hit(h4), .q_miss(m4), .q_idle(i4), .err(e4));

    int n_chk  = 0;
    int n_fail = 0;

    // reference models
    bit            o8 [8];
    logic [RW-1:0] w8 [8];
    int            c8;
    bit            o4 [4];
    logic [RW-1:0] w4 [4];
    int            c4;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit ill8(logic [1:0] o, logic [2:0] bb, logic [RW-1:0] rr);
        case (o)
            2'b00:   return o8[bb] || (c8 >= 4);
            2'b01:   return 1'b0;
            default: return !o8[bb] || (w8[bb] != rr);
        endcase
    endfunction

    function automatic bit ill4(logic [1:0] o, logic [1:0] bb, logic [RW-1:0] rr);
        case (o)
            2'b00:   return o4[bb] || (c4 >= 4);
            2'b01:   return 1'b0;
            default: return !o4[bb] || (w4[bb] != rr);
        endcase
    endfunction

    task automatic upd8(logic [1:0] o, bit a, logic [2:0] bb, logic [RW-1:0] rr);
        if (o == 2'b00) begin
            o8[bb] = 1; w8[bb] = rr; c8++;
        end else if (o == 2'b01) begin
            if (a) begin
                for (int k = 0; k < 8; k++) o8[k] = 0;
                c8 = 0;
            end else if (o8[bb]) begin
                o8[bb] = 0; c8--;
            end
        end
    endtask

    task automatic upd4(logic [1:0] o, bit a, logic [1:0] bb, logic [RW-1:0] rr);
        if (o == 2'b00) begin
            o4[bb] = 1; w4[bb] = rr; c4++;
        end else if (o == 2'b01) begin
            if (a) begin
                for (int k = 0; k < 4; k++) o4[k] = 0;
                c4 = 0;
            end else if (o4[bb]) begin
                o4[bb] = 0; c4--;
            end
        end
    endtask

    // one command cycle, then check the registered error of both copies
    task automatic step(bit vld, logic [1:0] o, bit a, logic [2:0] bb,
                        logic [RW-1:0] rr, string req);
        bit x8, x4;
        @(negedge clk);
        x8 = vld && ill8(o, bb, rr);
        x4 = vld && ill4(o, bb[1:0], rr);
        v = vld; op = o; all = a; b = bb; r = rr;
        @(negedge clk);
        v = 1'b0;
        chk(e8 == x8, req, "err (8 banks)", int'(e8), int'(x8));
        chk(e4 == x4, req, "err (4 banks)", int'(e4), int'(x4));
        if (vld && !x8) upd8(o, a, bb, rr);
        if (vld && !x4) upd4(o, a, bb[1:0], rr);
    endtask

    // query encoding compared as {hit,miss,idle}
    task automatic qcheck(logic [2:0] bb, logic [RW-1:0] rr, string req);
        logic [2:0] x8, x4;
        qb = bb; qr = rr;
        #1;
        x8 = o8[bb] ? ((w8[bb] == rr) ? 3'b100 : 3'b010) : 3'b001;
        x4 = o4[bb[1:0]] ? ((w4[bb[1:0]] == rr) ? 3'b100 : 3'b010) : 3'b001;
        chk({h8, m8, i8} == x8, req, "query (8 banks)", int'({h8, m8, i8}), int'(x8));
        chk({h4, m4, i4} == x4, req, "query (4 banks)", int'({h4, m4, i4}), int'(x4));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 8; k++) begin o8[k] = 0; w8[k] = '0; end
        for (int k = 0; k < 4; k++) begin o4[k] = 0; w4[k] = '0; end
        c8 = 0; c4 = 0;
        rst_n = 1'b0; v = 0; op = 0; all = 0; b = 0; r = 0; qb = 0; qr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(e8 == 1'b0, "R1", "err after reset", int'(e8), 0);
        for (int k = 0; k < 8; k++) qcheck(3'(k), 8'd0, "R1");

        // R2 / R9: open banks 0..3 on both copies
        for (int k = 0; k < 4; k++) step(1, 2'b00, 0, 3'(k), 8'(10 + k), "R2");
        for (int k = 0; k < 4; k++) begin
            qcheck(3'(k), 8'(10 + k), "R9");
            qcheck(3'(k), 8'(99), "R2");
        end

        // R8: fifth bank refused on the eight-bank copy (the four-bank copy sees bank 0 open: R6)
        step(1, 2'b00, 0, 3'd4, 8'd50, "R8");
        qcheck(3'd4, 8'd50, "R8");

        // R6: activate to an open bank
        step(1, 2'b00, 0, 3'd1, 8'd77, "R6");
        qcheck(3'd1, 8'd11, "R6");

        // R7: wrong row and idle bank, then legal access to the open row
        step(1, 2'b10, 0, 3'd2, 8'd13, "R7");
        step(1, 2'b11, 0, 3'd5, 8'd0, "R7");
        step(1, 2'b10, 0, 3'd2, 8'd12, "R7");
        step(1, 2'b11, 0, 3'd3, 8'd13, "R7");
        qcheck(3'd2, 8'd12, "R7");

        // R10: idle cycle leaves err low
        step(0, 2'b00, 0, 3'd6, 8'd0, "R10");

        // R3: single-bank precharge, then again on the now idle bank
        step(1, 2'b01, 0, 3'd2, 8'd0, "R3");
        qcheck(3'd2, 8'd12, "R3");
        step(1, 2'b01, 0, 3'd2, 8'd0, "R3");
        step(1, 2'b00, 0, 3'd6, 8'd60, "R3");
        qcheck(3'd6, 8'd60, "R3");

        // R4: precharge all with an arbitrary bank field, then refill to the limit
        step(1, 2'b01, 1, 3'd5, 8'd0, "R4");
        for (int k = 0; k < 8; k++) qcheck(3'(k), 8'd0, "R4");
        for (int k = 4; k < 8; k++) step(1, 2'b00, 0, 3'(k), 8'(k), "R4");
        for (int k = 4; k < 8; k++) qcheck(3'(k), 8'(k), "R4");

        // constrained random mix
        for (int it = 0; it < 1500; it++) begin
            int sel;
            logic [1:0] o;
            bit a;
            sel = int'($urandom % 10);
            a = 0;
            if (sel < 4)       o = 2'b00;
            else if (sel < 7) begin
                o = 2'b01;
                a = (($urandom % 5) == 0);
            end
            else if (sel < 9)  o = 2'b10;
            else               o = 2'b11;
            step(($urandom % 8) != 0, o, a, 3'($urandom % 8), 8'($urandom % 4), "R7");
            qcheck(3'($urandom % 8), 8'($urandom % 4), "R5");
        end

        finish_run();
    end

endmodule